// File: doc/BRIEF.md
# Self-testable two-level AND-OR logic array

This block is a two-level AND-OR logic array with `N_IN` inputs, `N_COL` product terms and `N_OUT` outputs. The AND and OR connection patterns come from parameters. Test hardware is added around the array so that one fixed test set checks any programmed function. That test set depends only on the array's dimensions.

Each input feeds a true literal row and a complemented literal row. Two control inputs can force either family of rows high. A column-select shift register holds one bit per product term, and every product term is ANDed with its own bit. An extra AND-plane column makes the connection count of every literal row odd. An extra OR-plane row makes the connection count of every product column odd. Two XOR chains then report parity:

- `z1` covers the product columns.
- `z2` covers the OR rows.

In normal use the control inputs are low and the select register holds all ones. A fault-injection port lets a bench place one stuck line or one flipped crosspoint, so that it can confirm the parity outputs reveal that fault.

Top module: `tpla_top`

## Requirements
- R1: With the select register all ones and `y_true = y_comp = 0`, each output `f[k]` is the OR of the product terms linked to it. A product term is the AND of its linked literals, gated by its select bit `sel[j]`.
- R2: Literal row 2i is `x[i] | y_true` and literal row 2i+1 is `~x[i] | y_comp`. With `y_true = 1`, every true row is high whatever `x` is.
- R3: The select register resets to all ones. While `sr_shift` is high, each clock moves `sr_din` into `sel[0]` and `sel[j-1]` into `sel[j]`. While `sr_shift` is low, the register holds. `sr_out` is `sel[N_COL-1]`.
- R4: The extra AND column links each literal row that has an even number of links among the product columns. This column is not gated by the select register, and it drives no OR row.
- R5: The extra OR row links each product column that has an even number of links to the function outputs.
- R6: `z1` is the XOR of all gated product terms and the extra AND column. With all rows high and all columns selected, `z1` equals the parity of `N_COL+1` ones.
- R7: `z2` is the XOR of all function outputs and the extra OR row. With nothing selected and no fault, `f` is 0 and `z2` is 0.
- R8: `fault_mode` selects one fault:
  - 0: none.
  - 1 / 2: literal row `fault_row` stuck at 0 / 1.
  - 3 / 4: effective column `fault_col` stuck at 0 / 1. Column `N_COL` is the extra AND column.
  - 5 / 6: OR row `fault_row` stuck at 0 / 1. Row `N_OUT` is the extra OR row.
  - 7: flip the AND-plane link at literal row `fault_row`, column `fault_col`.
  - 8: flip the OR-plane link at OR row `fault_row`, product column `fault_col`.
  - Any other code has no effect.
- R9: With all rows high, exactly one column selected and no fault, `z2 = 1`, `z1 = 0`, and `f[k]` shows whether column j links to output k.
- R10: With all columns selected, no fault, and exactly one literal row driven low (all others high), `z1` is the complement of its all-rows-high value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select register |
| rst_n | input | 1 | Asynchronous active-low reset |
| x | input | N_IN | Function inputs |
| y_true | input | 1 | Forces all true literal rows high |
| y_comp | input | 1 | Forces all complemented literal rows high |
| sr_shift | input | 1 | Shift strobe for the select register |
| sr_din | input | 1 | Serial data into select bit 0 |
| fault_mode | input | 4 | Injected fault kind (R8 codes) |
| fault_row | input | RW | Row index for an injected fault |
| fault_col | input | CW | Column index for an injected fault |
| f | output | N_OUT | Function outputs |
| z1 | output | 1 | Product-column parity |
| z2 | output | 1 | OR-row parity |
| sr_out | output | 1 | Last select bit |

## Verification
The bench builds the block with four inputs, six product terms and two outputs. The programmed function gives literal rows with both odd and even link counts, so the extra AND column has some rows linked and some not. Two product columns link to both outputs, so the extra OR row is non-empty and `z2` differs from the plain XOR of the outputs. With six columns the all-rows-high value of `z1` is 1, so a single sensitized row drives it to 0. Every fault kind can be placed at a site where the parity outputs or `f` expose it.

// File: rtl/tpla_pkg.sv
`timescale 1ns/1ps
package tpla_pkg;

   typedef enum logic [3:0] {
      FLT_NONE   = 4'd0,
      FLT_LIT_S0 = 4'd1,
      FLT_LIT_S1 = 4'd2,
      FLT_COL_S0 = 4'd3,
      FLT_COL_S1 = 4'd4,
      FLT_ROW_S0 = 4'd5,
      FLT_ROW_S1 = 4'd6,
      FLT_XP_AND = 4'd7,
      FLT_XP_OR  = 4'd8
   } fault_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int idx_w(input int n);
      return (n < 3) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tpla_literals.sv
`timescale 1ns/1ps
module tpla_literals
   import tpla_pkg::*;
#(
   parameter int N_IN = 4,
   parameter int RW   = 3,
   localparam int ROWS = 2 * N_IN
) (
   input  logic [N_IN-1:0] x,
   input  logic            y_true,
   input  logic            y_comp,
   input  fault_e          mode,
   input  logic [RW-1:0]   frow,
   output logic [ROWS-1:0] lit
);

   logic [ROWS-1:0] raw;

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_in
         assign raw[2*i]   = x[i] | y_true;
         assign raw[2*i+1] = ~x[i] | y_comp;
      end
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic hit;
         assign hit    = (frow == RW'(r));
         assign lit[r] = (hit && mode == FLT_LIT_S0) ? 1'b0 :
                         (hit && mode == FLT_LIT_S1) ? 1'b1 : raw[r];
      end
   endgenerate

endmodule

// File: rtl/tpla_colsel.sv
`timescale 1ns/1ps
module tpla_colsel #(
   parameter int N_COL = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic             din,
   output logic [N_COL-1:0] sel,
   output logic             dout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= '1;
      end else if (shift) begin
         sel <= {sel[N_COL-2:0], din};
      end
   end

   assign dout = sel[N_COL-1];

endmodule

// File: rtl/tpla_and_plane.sv
`timescale 1ns/1ps
module tpla_and_plane
   import tpla_pkg::*;
#(
   parameter int N_IN  = 4,
   parameter int N_COL = 6,
   parameter logic [N_COL*N_IN-1:0] AND_POS = '0,
   parameter logic [N_COL*N_IN-1:0] AND_NEG = '0,
   parameter int RW = 3,
   parameter int CW = 3,
   localparam int ROWS = 2 * N_IN
) (
   input  logic [ROWS-1:0]  lit,
   input  logic [N_COL-1:0] sel,
   input  fault_e           mode,
   input  logic [RW-1:0]    frow,
   input  logic [CW-1:0]    fcol,
   output logic [N_COL:0]   term
);

   function automatic logic base_link(input int r, input int c);
      if (c >= N_COL) return 1'b0;
      if (r % 2 == 0) return AND_POS[c*N_IN + r/2];
      return AND_NEG[c*N_IN + r/2];
   endfunction

   function automatic logic par_link(input int r);
      logic acc;
      acc = 1'b0;
      for (int c = 0; c < N_COL; c++) acc ^= base_link(r, c);
      return ~acc;
   endfunction

   generate
      for (genvar c = 0; c <= N_COL; c++) begin : g_col
         logic [ROWS-1:0] need;
         logic            raw;
         logic            gated;
         logic            chit;
         for (genvar r = 0; r < ROWS; r++) begin : g_xp
            localparam logic LINK = (c == N_COL) ? par_link(r) : base_link(r, c);
            assign need[r] = LINK ^ (mode == FLT_XP_AND && frow == RW'(r) && fcol == CW'(c));
         end
         assign raw = &(lit | ~need);
         if (c < N_COL) begin : g_gate
            assign gated = raw & sel[c];
         end else begin : g_free
            assign gated = raw;
         end
         assign chit    = (fcol == CW'(c));
         assign term[c] = (chit && mode == FLT_COL_S0) ? 1'b0 :
                          (chit && mode == FLT_COL_S1) ? 1'b1 : gated;
      end
   endgenerate

endmodule

// File: rtl/tpla_or_plane.sv
`timescale 1ns/1ps
module tpla_or_plane
   import tpla_pkg::*;
#(
   parameter int N_COL = 6,
   parameter int N_OUT = 2,
   parameter logic [N_OUT*N_COL-1:0] OR_MAP = '0,
   parameter int RW = 3,
   parameter int CW = 3
) (
   input  logic [N_COL-1:0] term,
   input  fault_e           mode,
   input  logic [RW-1:0]    frow,
   input  logic [CW-1:0]    fcol,
   output logic [N_OUT:0]   row
);

   function automatic logic out_link(input int k, input int c);
      if (k < N_OUT) return OR_MAP[k*N_COL + c];
      return ~(^OR_MAP[c +: 1] ^ col_par(c));
   endfunction

   function automatic logic col_par(input int c);
      logic acc;
      acc = 1'b0;
      for (int k = 1; k < N_OUT; k++) acc ^= OR_MAP[k*N_COL + c];
      return acc;
   endfunction

   generate
      for (genvar k = 0; k <= N_OUT; k++) begin : g_row
         logic [N_COL-1:0] need;
         logic             raw;
         logic             rhit;
         for (genvar c = 0; c < N_COL; c++) begin : g_xp
            localparam logic LINK = out_link(k, c);
            assign need[c] = LINK ^ (mode == FLT_XP_OR && frow == RW'(k) && fcol == CW'(c));
         end
         assign raw    = |(term & need);
         assign rhit   = (frow == RW'(k));
         assign row[k] = (rhit && mode == FLT_ROW_S0) ? 1'b0 :
                         (rhit && mode == FLT_ROW_S1) ? 1'b1 : raw;
      end
   endgenerate

endmodule

// File: rtl/tpla_xor_chain.sv
`timescale 1ns/1ps
module tpla_xor_chain #(
   parameter int W = 4
) (
   input  logic [W-1:0] d,
   output logic         q
);

   logic [W-1:0] acc;

   generate
      assign acc[0] = d[0];
      for (genvar i = 1; i < W; i++) begin : g_stage
         assign acc[i] = acc[i-1] ^ d[i];
      end
   endgenerate

   assign q = acc[W-1];

endmodule

// File: rtl/tpla_top.sv
`timescale 1ns/1ps
module tpla_top
   import tpla_pkg::*;
#(
   parameter int N_IN  = 4,
   parameter int N_COL = 6,
   parameter int N_OUT = 2,
   parameter logic [N_COL*N_IN-1:0]  AND_POS = 24'h182601,
   parameter logic [N_COL*N_IN-1:0]  AND_NEG = 24'h405080,
   parameter logic [N_OUT*N_COL-1:0] OR_MAP  = 12'hF0F,
   localparam int ROWS = 2 * N_IN,
   localparam int RW   = idx_w(max2(ROWS, N_OUT + 1)),
   localparam int CW   = idx_w(N_COL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IN-1:0]  x,
   input  logic             y_true,
   input  logic             y_comp,
   input  logic             sr_shift,
   input  logic             sr_din,
   input  logic [3:0]       fault_mode,
   input  logic [RW-1:0]    fault_row,
   input  logic [CW-1:0]    fault_col,
   output logic [N_OUT-1:0] f,
   output logic             z1,
   output logic             z2,
   output logic             sr_out
);

   generate
      if (N_IN < 1)  begin : g_bad_in  $error("N_IN must be at least 1");  end
      if (N_COL < 2) begin : g_bad_col $error("N_COL must be at least 2"); end
      if (N_OUT < 1) begin : g_bad_out $error("N_OUT must be at least 1"); end
   endgenerate

   fault_e           fmode;
   logic [ROWS-1:0]  lit;
   logic [N_COL-1:0] col_sel;
   logic [N_COL:0]   term;
   logic [N_OUT:0]   orow;

   assign fmode = fault_e'(fault_mode);

   tpla_literals #(.N_IN(N_IN), .RW(RW)) u_lit (
      .x(x), .y_true(y_true), .y_comp(y_comp),
      .mode(fmode), .frow(fault_row), .lit(lit)
   );

   tpla_colsel #(.N_COL(N_COL)) u_sel (
      .clk(clk), .rst_n(rst_n), .shift(sr_shift), .din(sr_din),
      .sel(col_sel), .dout(sr_out)
   );

   tpla_and_plane #(
      .N_IN(N_IN), .N_COL(N_COL), .AND_POS(AND_POS), .AND_NEG(AND_NEG),
      .RW(RW), .CW(CW)
   ) u_and (
      .lit(lit), .sel(col_sel), .mode(fmode),
      .frow(fault_row), .fcol(fault_col), .term(term)
   );

   tpla_or_plane #(
      .N_COL(N_COL), .N_OUT(N_OUT), .OR_MAP(OR_MAP), .RW(RW), .CW(CW)
   ) u_or (
      .term(term[N_COL-1:0]), .mode(fmode),
      .frow(fault_row), .fcol(fault_col), .row(orow)
   );

   tpla_xor_chain #(.W(N_COL + 1)) u_z1 (.d(term), .q(z1));
   tpla_xor_chain #(.W(N_OUT + 1)) u_z2 (.d(orow), .q(z2));

   assign f = orow[N_OUT-1:0];

endmodule

// File: rtl/tpla_checker.sv
`timescale 1ns/1ps
module tpla_checker #(
   parameter int N_IN  = 4,
   parameter int N_COL = 6,
   parameter int N_OUT = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_IN-1:0]  x,
   input logic             y_true,
   input logic             y_comp,
   input logic             sr_shift,
   input logic             sr_din,
   input logic [3:0]       fault_mode,
   input logic [N_OUT-1:0] f,
   input logic             z1,
   input logic             z2,
   input logic [N_COL-1:0] sel
);

   localparam logic ALL_ON = ((N_COL + 1) % 2) == 1;

   p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sr_shift |=> sel == {$past(sel[N_COL-2:0]), $past(sr_din)});

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_shift |=> $stable(sel));

   p_all_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_mode == 4'd0 && y_true && y_comp && &sel) |-> z1 == ALL_ON);

   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_mode == 4'd0 && sel == '0) |-> (f == '0 && !z2));

   p_one_col_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_mode == 4'd0 && y_true && y_comp && $onehot(sel)) |-> (z2 && !z1));

   p_sens_true_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_mode == 4'd0 && y_true && !y_comp && &sel && $onehot(x)) |-> z1 != ALL_ON);

   p_sens_comp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_mode == 4'd0 && !y_true && y_comp && &sel && $onehot(~x)) |-> z1 != ALL_ON);

endmodule

bind tpla_top tpla_checker #(.N_IN(N_IN), .N_COL(N_COL), .N_OUT(N_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .x(x), .y_true(y_true), .y_comp(y_comp),
   .sr_shift(sr_shift), .sr_din(sr_din), .fault_mode(fault_mode),
   .f(f), .z1(z1), .z2(z2), .sel(col_sel)
);

// File: tb/tb_tpla_top.sv
`timescale 1ns/1ps
module tb_tpla_top;

   localparam int NI = 4;
   localparam int NC = 6;
   localparam int NO = 2;
   localparam logic [NC*NI-1:0] P_POS = 24'h182601;
   localparam logic [NC*NI-1:0] P_NEG = 24'h405080;
   localparam logic [NO*NC-1:0] P_OR  = 12'hF0F;
   localparam int RW = 3;
   localparam int CW = 3;

   // {x[3:0], y_true, y_comp, f[1:0]} with the select register all ones
   localparam logic [7:0] VEC [8] = '{
      8'b0000_00_01, 8'b1000_00_10, 8'b0110_00_11, 8'b1010_00_11,
      8'b1001_00_11, 8'b1100_00_10, 8'b1101_00_11, 8'b0000_11_11
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NI-1:0] x;
   logic          y_true, y_comp, sr_shift, sr_din;
   logic [3:0]    fault_mode;
   logic [RW-1:0] fault_row;
   logic [CW-1:0] fault_col;
   logic [NO-1:0] f;
   logic          z1, z2, sr_out;

   int  nchk  = 0;
   int  nfail = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   tpla_top #(.N_IN(NI), .N_COL(NC), .N_OUT(NO),
              .AND_POS(P_POS), .AND_NEG(P_NEG), .OR_MAP(P_OR)) dut (
      .clk(clk), .rst_n(rst_n), .x(x), .y_true(y_true), .y_comp(y_comp),
      .sr_shift(sr_shift), .sr_din(sr_din), .fault_mode(fault_mode),
      .fault_row(fault_row), .fault_col(fault_col),
      .f(f), .z1(z1), .z2(z2), .sr_out(sr_out)
   );

   // fault-free reference built from the requirements: {f, z1, z2}
   function automatic logic [3:0] model(input logic [3:0] xv, input logic a,
                                        input logic c, input logic [5:0] s);
      logic [5:0] b;
      logic       pp, ex, rv;
      logic [1:0] fm;
      int         cnt;
      for (int j = 0; j < NC; j++) begin
         b[j] = s[j];
         for (int i = 0; i < NI; i++) begin
            if (P_POS[j*NI+i] && !(xv[i] | a)) b[j] = 1'b0;
            if (P_NEG[j*NI+i] && !(!xv[i] | c)) b[j] = 1'b0;
         end
      end
      pp = 1'b1;
      for (int r = 0; r < 2*NI; r++) begin
         cnt = 0;
         for (int j = 0; j < NC; j++)
            cnt += int'((r % 2 == 0) ? P_POS[j*NI + r/2] : P_NEG[j*NI + r/2]);
         rv = (r % 2 == 0) ? (xv[r/2] | a) : (!xv[r/2] | c);
         if (cnt % 2 == 0 && !rv) pp = 1'b0;
      end
      for (int k = 0; k < NO; k++) fm[k] = |(b & P_OR[k*NC +: NC]);
      ex = 1'b0;
      for (int j = 0; j < NC; j++)
         if ((int'(P_OR[j]) + int'(P_OR[NC+j])) % 2 == 0) ex |= b[j];
      return {fm, ^b ^ pp, fm[0] ^ fm[1] ^ ex};
   endfunction

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [3:0] xv, input logic a, input logic c,
                        input logic [3:0] m, input int row, input int col);
      @(negedge clk);
      x = xv; y_true = a; y_comp = c; fault_mode = m;
      fault_row = RW'(row); fault_col = CW'(col);
      #1;
   endtask

   task automatic shift1(input logic b);
      @(negedge clk);
      sr_shift = 1'b1; sr_din = b;
      @(negedge clk);
      sr_shift = 1'b0;
   endtask

   task automatic load_sel(input logic [5:0] pat);
      for (int t = 0; t < NC; t++) shift1(pat[NC-1-t]);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      rst_n = 1'b0; x = '0; y_true = 1'b0; y_comp = 1'b0;
      sr_shift = 1'b0; sr_din = 1'b0; fault_mode = '0; fault_row = '0; fault_col = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R3 reset sr_out", {7'd0, sr_out}, 8'd1);

      // table walk with all columns selected
      for (int v = 0; v < 8; v++) begin
         drive(VEC[v][7:4], VEC[v][3], VEC[v][2], 4'd0, 0, 0);
         chk("R1 function", {6'd0, f}, {6'd0, VEC[v][1:0]});
         chk("R6 z1", {7'd0, z1}, {7'd0, model(VEC[v][7:4], VEC[v][3], VEC[v][2], 6'h3F)[1]});
         chk("R7 z2", {7'd0, z2}, {7'd0, model(VEC[v][7:4], VEC[v][3], VEC[v][2], 6'h3F)[0]});
      end

      // R2: y_true lifts every true row, complemented rows then high too (x=0)
      drive(4'b0000, 1'b1, 1'b0, 4'd0, 0, 0);
      chk("R2 true rows forced", {4'd0, f, z1, z2}, 8'b0000_1111);

      // R10: one complemented row low (x2 row 5) then one true row low (x0 row 0)
      drive(4'b0100, 1'b1, 1'b0, 4'd0, 0, 0);
      chk("R10 sensitized comp row", {4'd0, f, z1, z2}, 8'b0000_1101);
      drive(4'b1110, 1'b0, 1'b1, 4'd0, 0, 0);
      chk("R10 sensitized true row", {7'd0, z1}, 8'd0);

      // R8: AND crosspoint flip on the sensitized row is revealed by z1
      drive(4'b0100, 1'b1, 1'b0, 4'd7, 5, 3);
      chk("R8 AND crosspoint flip", {7'd0, z1}, 8'd1);
      // R8 literal stuck-at-0 on true row of x2 (row 4)
      drive(4'b0000, 1'b1, 1'b1, 4'd1, 4, 0);
      chk("R8 literal stuck0", {7'd0, z1}, 8'd0);
      // R8 unused code has no effect
      drive(4'b0000, 1'b1, 1'b1, 4'd12, 4, 0);
      chk("R8 unused code", {4'd0, f, z1, z2}, 8'b0000_1111);

      // R9 / R4 / R5: each column alone with all rows high
      for (int j = 0; j < NC; j++) begin
         load_sel(6'(1 << j));
         drive(4'b0000, 1'b1, 1'b1, 4'd0, 0, 0);
         chk("R9 single column f", {6'd0, f}, {6'd0, P_OR[NC+j], P_OR[j]});
         chk("R9 single column parity", {6'd0, z1, z2}, 8'b01);
      end

      // R8 OR crosspoint flip at output 0, column 4, with column 4 selected
      load_sel(6'b010000);
      drive(4'b0000, 1'b1, 1'b1, 4'd8, 0, 4);
      chk("R8 OR crosspoint flip", {5'd0, f, z2}, 8'b110);

      // nothing selected
      load_sel(6'b000000);
      drive(4'b0000, 1'b1, 1'b1, 4'd0, 0, 0);
      chk("R7 idle", {4'd0, f, z1, z2}, 8'b0000_0010);
      chk("R4 parity column ungated", {7'd0, z1}, 8'd1);
      drive(4'b0000, 1'b1, 1'b1, 4'd3, 0, 6);
      chk("R8 parity column stuck0", {7'd0, z1}, 8'd0);
      drive(4'b0000, 1'b1, 1'b1, 4'd4, 0, 1);
      chk("R8 column stuck1", {4'd0, f, z1, z2}, 8'b0000_0101);
      drive(4'b0000, 1'b1, 1'b1, 4'd6, 2, 0);
      chk("R5 extra row stuck1", {5'd0, f, z2}, 8'b001);
      drive(4'b0000, 1'b1, 1'b1, 4'd0, 0, 0);

      // R3 serial path
      chk("R3 sr_out after zeros", {7'd0, sr_out}, 8'd0);
      shift1(1'b1);
      for (int t = 0; t < NC - 2; t++) shift1(1'b0);
      #1;
      chk("R3 sr_out before arrival", {7'd0, sr_out}, 8'd0);
      shift1(1'b0);
      #1;
      chk("R3 sr_out on arrival", {7'd0, sr_out}, 8'd1);
      repeat (4) @(posedge clk);
      drive(4'b0000, 1'b1, 1'b1, 4'd0, 0, 0);
      chk("R3 hold without strobe", {5'd0, f, z2}, 8'b101);

      // R3 reset restores all ones
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R3 reset to ones", {4'd0, f, z1, z2}, 8'b0000_1111);
      chk("R3 reset sr_out again", {7'd0, sr_out}, 8'd1);

      summary();
   end

endmodule